// File: doc/BRIEF.md
# Branch and Call Program Sequencer

This block owns the program counter of a small DSP core and carries out its control-transfer instructions. Decode hands it one operation at a time, each with an already evaluated condition flag and a marker for the conditional encoding. The operations are an immediate jump or call, a jump or call through the pointer register, a return, an interrupt return and an interrupt call. The block then holds fetch off with `busy_o` for as many cycles as the instruction needs. On the final cycle it presents the new fetch address. Between control instructions, `adv_i` steps the counter by one.

An immediate target takes only 12 bits from the instruction. The page bits above them come from the counter after it has advanced past the whole instruction. A transfer that sits in the last slots of a 4K-word page therefore lands in the following page. A taken call saves the address after the instruction in the return-address register `pr_o`.

Top module: `ctl_seq`

## Requirements
- R1: After reset, `fetch_addr_o` is 0, `pr_o` is 0 and `busy_o` is low.
- R2: While idle, with `start_i` low and `adv_i` high, `fetch_addr_o` increases by one on each clock edge.
- R3: An operation with `cond_form_i`=0, other than the interrupt call, takes two cycles. `busy_o` is high only in the start cycle, and the target appears on `fetch_addr_o` in the next cycle.
- R4: The interrupt call (`op_i`=6) takes three cycles whatever `cond_form_i` is. It jumps to parameter `ICALL_VEC` (default 0x0002) and leaves `pr_o` unchanged.
- R5: Any operation with `cond_form_i`=1, other than codes 5 and 6, takes three cycles. `busy_o` is high in the first two cycles, `fetch_addr_o` holds during the middle cycle and shows the result in the third cycle.
- R6: An immediate jump (`op_i`=0) or call (`op_i`=1) goes to {A[15:12], `imm_i`}. A is the current address plus the instruction length: 1 word unconditional, 2 words conditional. An instruction at 0x2FFF, or a conditional one at 0x4FFE, lands in the next page.
- R7: A pointer jump (2) or call (3) goes to `ptr_i`. A return (4) goes to `pr_o`, and an interrupt return (5) goes to `irp_i`.
- R8: A taken call (codes 1 and 3) writes the current address plus the instruction length into `pr_o`. Jumps and returns leave `pr_o` unchanged.
- R9: When `cond_form_i`=1 and `cond_true_i`=0, the result address is the current address plus 2 and `pr_o` is unchanged.
- R10: For codes 5 and 6, `cond_form_i` and `cond_true_i` have no effect; the interrupt return always takes two cycles and is taken.
- R11: `start_i` and `adv_i` have no effect while a three-cycle transfer is in progress. `start_i` has priority over `adv_i`, and a new `start_i` is accepted in the final cycle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Decoded control operation present |
| op_i | input | 3 | Operation code (0 jmp imm, 1 call imm, 2 jmp ptr, 3 call ptr, 4 ret, 5 iret, 6 icall) |
| cond_form_i | input | 1 | Instruction uses the two-word conditional encoding |
| cond_true_i | input | 1 | Evaluated condition |
| adv_i | input | 1 | Step the counter by one (non-control instruction) |
| imm_i | input | 12 | Immediate low-address field |
| ptr_i | input | 16 | Pointer register |
| irp_i | input | 16 | Interrupt-return register |
| fetch_addr_o | output | 16 | Program counter / fetch address |
| pr_o | output | 16 | Return-address register |
| busy_o | output | 1 | Fetch stall |

## Verification
Two pairs of functions can meet in one cycle. A sequential step can arrive together with a transfer start, and a new transfer can start in the final cycle of a previous one. The bench raises `adv_i` together with `start_i`, and it presents a second start and a step during the middle cycle of a three-cycle transfer. Each result is judged by the address that follows: the first transfer's target with no extra increment. It also starts a transfer in the cycle where the previous target first shows and checks that both targets arrive in turn.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  typedef enum logic [2:0] {
    OP_JMP_IMM  = 3'd0,
    OP_CALL_IMM = 3'd1,
    OP_JMP_PTR  = 3'd2,
    OP_CALL_PTR = 3'd3,
    OP_RET      = 3'd4,
    OP_IRET     = 3'd5,
    OP_ICALL    = 3'd6,
    OP_RSVD     = 3'd7
  } ctl_op_e;
endpackage

// File: rtl/ctl_target.sv
module ctl_target
  import ctl_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned IW = 12,
  parameter logic [AW-1:0] ICALL_VEC = AW'(2)
) (
  input  ctl_op_e          op_i,
  input  logic             cond_form_i,
  input  logic             cond_true_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [IW-1:0]    imm_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [AW-1:0]    pr_i,
  input  logic [AW-1:0]    irp_i,
  output logic [AW-1:0]    next_pc_o,
  output logic             pr_wr_o,
  output logic [AW-1:0]    pr_val_o,
  output logic             long_o
);
  logic          cond_eff, taken;
  logic [AW-1:0] fall, tgt;

  // interrupt ops have no conditional form
  assign cond_eff = cond_form_i && (op_i != OP_IRET) && (op_i != OP_ICALL);
  assign fall     = pc_i + (cond_eff ? AW'(2) : AW'(1));
  assign taken    = !cond_eff || cond_true_i;

  always_comb begin
    unique case (op_i)
      OP_JMP_IMM, OP_CALL_IMM: tgt = {fall[AW-1:IW], imm_i};
      OP_JMP_PTR, OP_CALL_PTR: tgt = ptr_i;
      OP_RET:                  tgt = pr_i;
      OP_IRET:                 tgt = irp_i;
      OP_ICALL:                tgt = ICALL_VEC;
      default:                 tgt = fall;
    endcase
  end

  assign next_pc_o = taken ? tgt : fall;
  assign pr_wr_o   = taken && (op_i == OP_CALL_IMM || op_i == OP_CALL_PTR);
  assign pr_val_o  = fall;
  assign long_o    = cond_eff || (op_i == OP_ICALL);
endmodule

// File: rtl/ctl_cyc_timer.sv
module ctl_cyc_timer #(
  parameter int unsigned MAX_CYC = 3,
  localparam int unsigned CW = $clog2(MAX_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [CW-1:0] cycles_i,
  output logic          active_o,
  output logic          load_direct_o,
  output logic          load_pend_o
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rem_q <= '0;
    else if (accept_i)         rem_q <= cycles_i - CW'(2);
    else if (rem_q != '0)      rem_q <= rem_q - CW'(1);
  end

  assign active_o      = (rem_q != '0);
  assign load_direct_o = accept_i && (cycles_i == CW'(2));
  assign load_pend_o   = (rem_q == CW'(1));
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned IW = 12,
  parameter logic [AW-1:0] ICALL_VEC = AW'(2),
  localparam int unsigned MAX_CYC = 3,
  localparam int unsigned CW = $clog2(MAX_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic          cond_form_i,
  input  logic          cond_true_i,
  input  logic          adv_i,
  input  logic [IW-1:0] imm_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] irp_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic [AW-1:0] pr_o,
  output logic          busy_o
);
  logic          active, ld_direct, ld_pend, accept;
  logic [AW-1:0] pc_q, pr_q, tgt_pc, tgt_pr_val, pend_pc, pend_pr_val;
  logic          tgt_pr_wr, tgt_long, pend_pr_wr;
  logic [CW-1:0] cycles;

  assign accept = start_i && !active;
  assign cycles = tgt_long ? CW'(3) : CW'(2);

  ctl_target #(.AW(AW), .IW(IW), .ICALL_VEC(ICALL_VEC)) u_tgt (
    .op_i        (ctl_op_e'(op_i)),
    .cond_form_i (cond_form_i),
    .cond_true_i (cond_true_i),
    .pc_i        (pc_q),
    .imm_i       (imm_i),
    .ptr_i       (ptr_i),
    .pr_i        (pr_q),
    .irp_i       (irp_i),
    .next_pc_o   (tgt_pc),
    .pr_wr_o     (tgt_pr_wr),
    .pr_val_o    (tgt_pr_val),
    .long_o      (tgt_long)
  );

  ctl_cyc_timer #(.MAX_CYC(MAX_CYC)) u_tmr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept),
    .cycles_i      (cycles),
    .active_o      (active),
    .load_direct_o (ld_direct),
    .load_pend_o   (ld_pend)
  );

  // result captured at accept, committed on the last busy edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_pc     <= '0;
      pend_pr_wr  <= 1'b0;
      pend_pr_val <= '0;
    end else if (accept) begin
      pend_pc     <= tgt_pc;
      pend_pr_wr  <= tgt_pr_wr;
      pend_pr_val <= tgt_pr_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      pr_q <= '0;
    end else if (ld_direct) begin
      pc_q <= tgt_pc;
      if (tgt_pr_wr) pr_q <= tgt_pr_val;
    end else if (ld_pend) begin
      pc_q <= pend_pc;
      if (pend_pr_wr) pr_q <= pend_pr_val;
    end else if (!active && !start_i && adv_i) begin
      pc_q <= pc_q + AW'(1);
    end
  end

  assign fetch_addr_o = pc_q;
  assign pr_o         = pr_q;
  assign busy_o       = start_i || active;
endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned IW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [2:0]    op_i,
  input logic          cond_form_i,
  input logic [IW-1:0] imm_i,
  input logic [AW-1:0] irp_i,
  input logic [AW-1:0] fetch_addr_o,
  input logic [AW-1:0] pr_o,
  input logic          busy_o,
  input logic          active_i,
  input logic          ld_direct_i,
  input logic          ld_pend_i
);
  logic          acc, intr_op;
  logic [AW-1:0] nxt, exp_imm;
  assign acc     = start_i && !active_i;
  assign intr_op = (op_i == 3'd5) || (op_i == 3'd6);
  assign nxt     = fetch_addr_o + AW'(1);
  assign exp_imm = {nxt[AW-1:IW], imm_i};

  assert_short_xfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !cond_form_i && op_i != 3'd6 |=> !busy_o || start_i);

  assert_icall_long_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == 3'd6 |=> busy_o);

  assert_cond_long_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cond_form_i && !intr_op |=> busy_o && $stable(fetch_addr_o));

  assert_imm_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !cond_form_i && op_i == 3'd0 |=> fetch_addr_o == $past(exp_imm));

  assert_iret_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == 3'd5 |=> fetch_addr_o == $past(irp_i));

  assert_pr_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_o != $past(pr_o) |-> $past(ld_direct_i || ld_pend_i));
endmodule

bind ctl_seq ctl_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .op_i         (op_i),
  .cond_form_i  (cond_form_i),
  .imm_i        (imm_i),
  .irp_i        (irp_i),
  .fetch_addr_o (fetch_addr_o),
  .pr_o         (pr_o),
  .busy_o       (busy_o),
  .active_i     (active),
  .ld_direct_i  (ld_direct),
  .ld_pend_i    (ld_pend)
);

// File: tb/sim_ctl_seq.sv
`timescale 1ns/1ps
module sim_ctl_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, cf = 1'b0, ct = 1'b0, adv = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [11:0] imm = '0;
  logic [15:0] ptr = '0, irp = '0;
  logic [15:0] fa, pr;
  logic        busy;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .cond_form_i(cf), .cond_true_i(ct), .adv_i(adv), .imm_i(imm),
    .ptr_i(ptr), .irp_i(irp), .fetch_addr_o(fa), .pr_o(pr), .busy_o(busy)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one transfer; checks busy profile, final address and pr
  task automatic xfer(string tag, logic [2:0] o, logic c_f, logic c_t,
                      logic [11:0] im, logic [15:0] p, logic [15:0] ip,
                      int ncyc, logic [15:0] exp_fa, logic [15:0] exp_pr);
    logic [15:0] old_fa;
    @(negedge clk);
    old_fa = fa;
    op = o; cf = c_f; ct = c_t; imm = im; ptr = p; irp = ip; start = 1'b1;
    #1 chk({tag, " busy start"}, 16'(busy), 16'd1);
    @(negedge clk);
    start = 1'b0; cf = 1'b0; ct = 1'b0;
    if (ncyc == 3) begin
      #1 chk({tag, " busy mid"}, 16'(busy), 16'd1);
      chk({tag, " hold mid"}, fa, old_fa);
      @(negedge clk);
    end
    #1 chk({tag, " busy end"}, 16'(busy), 16'd0);
    chk({tag, " addr"}, fa, exp_fa);
    chk({tag, " pr"}, pr, exp_pr);
  endtask

  task automatic t_reset();
    chk("R1 addr", fa, 16'h0);
    chk("R1 pr", pr, 16'h0);
    chk("R1 busy", 16'(busy), 16'd0);
  endtask

  task automatic t_adv();
    @(negedge clk); adv = 1'b1;
    repeat (3) @(negedge clk);
    adv = 1'b0;
    chk("R2 step", fa, 16'h0003);
  endtask

  task automatic t_uncond();
    xfer("R3 R7 jmp ptr", 3'd2, 0, 0, 12'h0, 16'h1234, 16'h0, 2, 16'h1234, 16'h0);
    xfer("R6 R8 call imm", 3'd1, 0, 0, 12'hABC, 16'h0, 16'h0, 2, 16'h1ABC, 16'h1235);
    xfer("R8 jmp ptr keeps pr", 3'd2, 0, 0, 12'h0, 16'h2FFF, 16'h0, 2, 16'h2FFF, 16'h1235);
  endtask

  task automatic t_page();
    xfer("R6 page cross", 3'd0, 0, 0, 12'h010, 16'h0, 16'h0, 2, 16'h3010, 16'h1235);
    xfer("R6 set", 3'd2, 0, 0, 12'h0, 16'h4FFE, 16'h0, 2, 16'h4FFE, 16'h1235);
    xfer("R5 R6 cond page", 3'd0, 1, 1, 12'h020, 16'h0, 16'h0, 3, 16'h5020, 16'h1235);
  endtask

  task automatic t_cond();
    xfer("R9 R5 cond false call", 3'd3, 1, 0, 12'h0, 16'h7777, 16'h0, 3, 16'h5022, 16'h1235);
    xfer("R5 R8 cond call ptr", 3'd3, 1, 1, 12'h0, 16'h6000, 16'h0, 3, 16'h6000, 16'h5024);
    xfer("R7 R5 cond ret", 3'd4, 1, 1, 12'h0, 16'h0, 16'h0, 3, 16'h5024, 16'h5024);
    xfer("R7 ret", 3'd4, 0, 0, 12'h0, 16'h0, 16'h0, 2, 16'h5024, 16'h5024);
  endtask

  task automatic t_intr();
    xfer("R10 R7 iret cond ignored", 3'd5, 1, 0, 12'h0, 16'h0, 16'h0ABC, 2, 16'h0ABC, 16'h5024);
    xfer("R4 R10 icall", 3'd6, 1, 0, 12'h0, 16'h0, 16'h0, 3, 16'h0002, 16'h5024);
  endtask

  task automatic t_overlap();
    // start with adv: start wins
    xfer("R11 set", 3'd2, 0, 0, 12'h0, 16'h0100, 16'h0, 2, 16'h0100, 16'h5024);
    @(negedge clk);
    op = 3'd2; ptr = 16'h0200; start = 1'b1; adv = 1'b1;
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
    #1 chk("R11 start over adv", fa, 16'h0200);
    // requests during middle cycle ignored
    op = 3'd2; cf = 1'b1; ct = 1'b1; ptr = 16'h0300; start = 1'b1;
    @(negedge clk);
    op = 3'd1; cf = 1'b0; imm = 12'h777; adv = 1'b1;
    #1 chk("R11 mid hold", fa, 16'h0200);
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
    #1 chk("R11 ignored in busy", fa, 16'h0300);
    chk("R11 pr untouched", pr, 16'h5024);
    // back-to-back: start in final cycle of previous transfer
    op = 3'd2; ptr = 16'h0400; start = 1'b1;
    @(negedge clk);
    ptr = 16'h0500;
    #1 chk("R11 b2b first", fa, 16'h0400);
    @(negedge clk);
    start = 1'b0;
    #1 chk("R11 b2b second", fa, 16'h0500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_adv();
    t_uncond();
    t_page();
    t_cond();
    t_intr();
    t_overlap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule